// File: doc/BRIEF.md
# Streaming Word Counter

This block counts words in a byte stream that arrives one byte per clock, qualified by a valid strobe. A two-state machine records whether the last accepted byte left the stream inside a word or between words. A 16-bit running total advances when a word finishes, not when it starts.

A word finishes in one of two ways. A separator byte can follow a word character, or a one-cycle end-of-stream pulse can arrive while a word is still open. The block has two outputs: the running total and the inside-word flag. The encoding of the state register is chosen at build time and has no effect on behaviour.

Top module: `word_tally`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears `word_total` to 0 and sets `in_word` to 0 (between words) for the following cycle.
- R2: The separator bytes are 0x20, 0x09, 0x0A and 0x0D. Every other byte value is a word character.
- R3: A valid separator accepted while `in_word` is 1 raises `word_total` by one and clears `in_word`.
- R4: A valid word character moves the machine to `in_word` = 1. A valid separator seen while `in_word` is 0 keeps `in_word` at 0. Neither case changes `word_total`.
- R5: In a cycle with `byte_valid` low and `stream_end` low, `word_total` and `in_word` hold their values.
- R6: A `stream_end` pulse taken while the machine is inside a word raises `word_total` by one and clears `in_word`. This holds whether or not `byte_valid` is high.
- R7: A `stream_end` pulse taken between words, with no word character in the same cycle, leaves `word_total` and `in_word` unchanged.
- R8: When a valid byte and `stream_end` arrive in the same cycle, the block applies the byte first and the pulse second. The word count therefore rises by at most one in that cycle, and `in_word` ends at 0.
- R9: `word_total` stops at 0xFFFF and never wraps.
- R10: Binary (`STATE_STYLE`=0), one-hot (1) and Gray (2) state encodings give identical outputs for identical input streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| byte_valid | input | 1 | `byte_in` carries a byte this cycle |
| byte_in | input | 8 | Stream byte |
| stream_end | input | 1 | One-cycle pulse that closes any open word |
| word_total | output | COUNT_W (16) | Saturating count of completed words |
| in_word | output | 1 | 1 when the machine is inside a word |

## Verification
The assertions rely on one input condition. The counter may only move while the machine is inside a word, or while a word character arrives together with `stream_end`. Because of that, the checks that the count rises by at most one per cycle and never falls are valid for any byte values. The stimulus drives each input only at the falling clock edge, and it holds `stream_end` low during idle stretches, so the hold property is exercised only in cycles that are truly quiet. To reach saturation quickly, the stimulus sends a single word character and an end-of-stream pulse in the same cycle, which completes one word per clock.

// File: rtl/word_tally.sv
module word_tally #(
  parameter int COUNT_W     = 16,
  parameter int STATE_STYLE = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               byte_valid,
  input  logic [7:0]         byte_in,
  input  logic               stream_end,
  output logic [COUNT_W-1:0] word_total,
  output logic               in_word
);

  localparam logic [COUNT_W-1:0] TOTAL_MAX = '1;

  logic is_sep, after_byte, closes, next_in;

  assign is_sep = (byte_in == 8'h20) || (byte_in == 8'h09) ||
                  (byte_in == 8'h0A) || (byte_in == 8'h0D);

  assign after_byte = byte_valid ? !is_sep : in_word;
  assign closes     = (byte_valid && in_word && is_sep) || (stream_end && after_byte);
  assign next_in    = after_byte && !stream_end;

  always_ff @(posedge clk) begin
    if (rst)
      word_total <= '0;
    else if (closes && word_total != TOTAL_MAX)
      word_total <= word_total + 1'b1;
  end

  generate
    if (STATE_STYLE == 1) begin : g_onehot
      logic [1:0] oh;
      always_ff @(posedge clk) begin
        if (rst) oh <= 2'b01;
        else     oh <= next_in ? 2'b10 : 2'b01;
      end
      assign in_word = (oh == 2'b10);
    end else if (STATE_STYLE == 2) begin : g_gray
      logic [1:0] gr;
      always_ff @(posedge clk) begin
        if (rst) gr <= 2'b00;
        else     gr <= next_in ? 2'b01 : 2'b00;
      end
      assign in_word = (gr == 2'b01);
    end else begin : g_binary
      logic st;
      always_ff @(posedge clk) begin
        if (rst) st <= 1'b0;
        else     st <= next_in;
      end
      assign in_word = st;
    end
  endgenerate

endmodule

// File: rtl/word_tally_chk.sv
module word_tally_chk #(
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               byte_valid,
  input logic               stream_end,
  input logic [COUNT_W-1:0] word_total,
  input logic               in_word
);

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (word_total == $past(word_total)) || (word_total == $past(word_total) + 1'b1));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!byte_valid && !stream_end) |=> ($stable(word_total) && $stable(in_word)));

  // R4
  out_no_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_word && !stream_end) |=> $stable(word_total));

  // R6
  end_closes_chk: assert property (@(posedge clk) disable iff (rst)
    stream_end |=> !in_word);

  // R9
  saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (&word_total) |=> (&word_total));

endmodule

bind word_tally word_tally_chk #(.COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rst(rst), .byte_valid(byte_valid), .stream_end(stream_end),
  .word_total(word_total), .in_word(in_word)
);

// File: tb/word_tally_tb.sv
module word_tally_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_valid = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic stream_end = 1'b0;
  logic [15:0] tot_b, tot_o, tot_g;
  logic in_b, in_o, in_g;

  int checks = 0;
  int fails = 0;
  int m_cnt = 0;
  bit m_in = 1'b0;
  int  q_cnt[$];
  bit  q_in[$];
  string q_tag[$];

  always #5 clk = ~clk;

  word_tally #(.STATE_STYLE(0)) u_dut (.clk(clk), .rst(rst), .byte_valid(byte_valid),
    .byte_in(byte_in), .stream_end(stream_end), .word_total(tot_b), .in_word(in_b));
  word_tally #(.STATE_STYLE(1)) u_dut_oh (.clk(clk), .rst(rst), .byte_valid(byte_valid),
    .byte_in(byte_in), .stream_end(stream_end), .word_total(tot_o), .in_word(in_o));
  word_tally #(.STATE_STYLE(2)) u_dut_gr (.clk(clk), .rst(rst), .byte_valid(byte_valid),
    .byte_in(byte_in), .stream_end(stream_end), .word_total(tot_g), .in_word(in_g));

  task automatic step(input bit r, input bit v, input logic [7:0] b, input bit e, input string tag);
    bit sep;
    bit mid;
    @(negedge clk);
    rst = r; byte_valid = v; byte_in = b; stream_end = e;
    sep = (b == 8'h20) || (b == 8'h09) || (b == 8'h0A) || (b == 8'h0D);
    if (r) begin
      m_cnt = 0; m_in = 1'b0;
    end else begin
      mid = m_in;
      if (v) begin
        if (m_in && sep && m_cnt < 65535) m_cnt++;
        mid = !sep;
      end
      if (e && mid) begin
        if (m_cnt < 65535) m_cnt++;
        mid = 1'b0;
      end
      m_in = mid;
    end
    q_cnt.push_back(m_cnt); q_in.push_back(m_in); q_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (q_cnt.size() > 0) begin
      int ec;
      bit ei;
      string t;
      ec = q_cnt.pop_front(); ei = q_in.pop_front(); t = q_tag.pop_front();
      checks++;
      if (int'(tot_b) != ec || in_b != ei) begin
        fails++;
        $display("FAIL %s binary: got cnt=%0d in=%0b exp cnt=%0d in=%0b", t, tot_b, in_b, ec, ei);
      end
      if (int'(tot_o) != ec || in_o != ei || int'(tot_g) != ec || in_g != ei) begin
        fails++;
        $display("FAIL R10 (%s): onehot cnt=%0d in=%0b gray cnt=%0d in=%0b exp cnt=%0d in=%0b",
                 t, tot_o, in_o, tot_g, in_g, ec, ei);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(1, 0, 8'h00, 0, "R1");
    step(1, 1, "a", 1, "R1");
    // R2 R3 R4: each separator ends a word
    step(0, 1, "h", 0, "R4");
    step(0, 1, "i", 0, "R4");
    step(0, 1, 8'h20, 0, "R3");
    step(0, 1, 8'h20, 0, "R4");
    step(0, 1, "x", 0, "R4");
    step(0, 1, 8'h09, 0, "R2");
    step(0, 1, "y", 0, "R4");
    step(0, 1, 8'h0A, 0, "R2");
    step(0, 1, "z", 0, "R4");
    step(0, 1, 8'h0D, 0, "R2");
    step(0, 1, 8'h00, 0, "R2");
    step(0, 1, 8'h21, 0, "R2");
    step(0, 1, 8'h0B, 0, "R2");
    // R5: idle keeps state, including a separator value on the bus
    step(0, 0, 8'h20, 0, "R5");
    step(0, 0, 8'h20, 0, "R5");
    step(0, 1, 8'h20, 0, "R3");
    // R7: end pulse between words
    step(0, 0, 8'h00, 1, "R7");
    step(0, 1, 8'h0A, 1, "R7");
    // R6: end pulse inside a word, with and without a byte
    step(0, 1, "q", 0, "R4");
    step(0, 0, 8'h20, 1, "R6");
    step(0, 1, "w", 0, "R4");
    step(0, 1, "w", 1, "R6");
    // R8: byte and end in same cycle
    step(0, 1, "k", 0, "R4");
    step(0, 1, 8'h20, 1, "R8");
    step(0, 1, "m", 1, "R8");
    step(0, 0, 8'h00, 0, "R5");
    // R1: reset mid-word
    step(0, 1, "p", 0, "R4");
    step(1, 0, 8'h00, 0, "R1");
    // R9: saturation, one word per cycle
    for (int i = 0; i < 65540; i++) step(0, 1, "s", 1, "R9");
    step(0, 1, "s", 0, "R9");
    step(0, 1, 8'h20, 0, "R9");
    step(0, 0, 8'h00, 0, "R9");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule